// File: doc/BRIEF.md
# Processor Clock-Stop Throttle Controller

This block drives a clock-stop request to a host processor, plus an optional cache-sleep companion signal, for power management. A slow timebase supplies a one-cycle pulse (`tick_i`) per 32 kHz period. The block uses that pulse to build a throttle period of eight ticks, about 244 µs. In each period the request is asserted for a programmable number of ticks, set in 12.5% steps, which makes the processor run slower on average.

Software controls the block through level inputs: a clock-control enable, a throttle enable, a burst-mode select, a sleep-follow enable and a 3-bit duty code. It also gives a one-cycle strobe when the level-2 entry register is read. Hardware gives a one-cycle event pulse. When burst mode is clear, that pulse acts as a break event. When burst mode is set, it acts as a burst event, which opens a fixed window of full-speed operation.

The controller has five states:
- `ST_RUN`: idle, full speed.
- `ST_THROTTLE`: periodic throttling.
- `ST_HOLD_THR`: continuous stop entered from throttling by a read; a break returns it to throttling.
- `ST_HOLD`: continuous stop with throttling disabled; a break fully releases it.
- `ST_BURST`: timed full-speed window.

The named transitions are:
- enable-throttle: RUN→THROTTLE
- read-hold: RUN or THROTTLE→HOLD_THR, or RUN→HOLD
- break-resume: HOLD_THR→THROTTLE
- break-release: HOLD→RUN
- throttle-upgrade: HOLD→THROTTLE
- burst-open: THROTTLE, HOLD or HOLD_THR→BURST
- burst-retrigger: BURST→BURST
- burst-close: BURST→saved state
- disable: any state→RUN

Top module: `clkstop_throttle`

## Requirements
- R1: After synchronous active-low reset, `clk_stop_o` and `cache_sleep_o` are 0 and the controller is idle. Read strobes and events have no effect while clock-control enable is 0. Events seen in the idle state are ignored.
- R2: While both enables are set and no read has occurred, the block throttles. A period is 8 ticks and starts at phase 0 on entry. The phase advances by one on each tick. `clk_stop_o` is 1 exactly when the phase is below the duty code n, so n of 8 ticks are stopped and a code of 0 never stops.
- R3: Clearing throttle enable ends throttling. `clk_stop_o` is 0 in the cycle after the clear.
- R4: A break event (event with burst mode 0) during throttling changes neither the state nor the phase.
- R5: A read strobe while both enables are set gives a continuous `clk_stop_o` = 1, independent of ticks.
- R6: A break event in the continuous stop entered under R5 resumes throttling at phase 0.
- R7: With throttle enable 0 and clock-control enable 1, a read strobe holds `clk_stop_o` at 1. A break then releases it to 0, and it stays 0 until another read strobe.
- R8: A burst event (event with burst mode 1) in any stop or throttle state forces `clk_stop_o` to 0 for 8 ticks. On the 8th tick the previous state resumes. A new burst event inside the window restarts the 8-tick count.
- R9: Clearing clock-control enable returns the block to idle from any state, burst included. `clk_stop_o` is 0 in the next cycle.
- R10: `cache_sleep_o` equals `clk_stop_o` when the sleep-follow enable is 1, and is 0 otherwise.
- R11: In the held stop of R7, setting throttle enable switches the block to throttling at phase 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_i | input | 1 | One-cycle pulse per 32 kHz timebase period |
| ctl_enable_i | input | 1 | Clock-control enable |
| thr_enable_i | input | 1 | Throttle enable |
| burst_mode_i | input | 1 | 1: hardware events are burst events; 0: break events |
| sleep_follow_i | input | 1 | Lets the cache-sleep output follow the stop request |
| duty_i | input | 3 | Stopped ticks per 8-tick period |
| entry_rd_i | input | 1 | One-cycle strobe: level-2 entry register read |
| hw_event_i | input | 1 | One-cycle hardware event pulse |
| clk_stop_o | output | 1 | Clock-stop request, active high |
| cache_sleep_o | output | 1 | Cache-sleep companion request, active high |

## Verification
The bench sweeps duty codes 0, 1, 3, 4, 6 and 7 over a full period and its wrap. A wrong phase comparison would show up as a shifted or extra stopped tick, and a missing wrap as a stuck output.

It checks that a break leaves throttling untouched, and that a break resumes throttling from the read-entered hold while it releases the plain hold for good. A design that merged these cases would either stop throttling on a break or stay stopped after one.

The burst window is timed edge by edge, both plainly and with a retrigger in its middle. A counter that is off by one, or that is not restarted, would release the stop a tick early or late.

Disabling from inside a burst window and upgrading a plain hold to throttling are both exercised.

// File: rtl/clkstop_pkg.sv
package clkstop_pkg;
    typedef enum logic [2:0] {
        ST_RUN      = 3'd0,
        ST_THROTTLE = 3'd1,
        ST_HOLD_THR = 3'd2,
        ST_HOLD     = 3'd3,
        ST_BURST    = 3'd4
    } thr_state_e;
endpackage

// File: rtl/clkstop_phase.sv
module clkstop_phase #(
    parameter int DUTY_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_i,
    input  logic              tick_i,
    output logic [DUTY_W-1:0] phase_o
);
    localparam logic [DUTY_W-1:0] PH_LAST = {DUTY_W{1'b1}};

    logic [DUTY_W-1:0] phase_q;

    always_ff @(posedge clk) begin
        if (!rst_n || !run_i) begin
            phase_q <= '0;
        end else if (tick_i) begin
            phase_q <= phase_q + 1'b1;
        end
    end

    assign phase_o = phase_q;

    AST_PHASE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && tick_i && phase_q == PH_LAST) |=> (phase_q == '0)); // R2
endmodule

// File: rtl/clkstop_burst.sv
module clkstop_burst #(
    parameter int BURST_TICKS = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic tick_i,
    output logic done_o
);
    localparam int BCW = (BURST_TICKS > 2) ? $clog2(BURST_TICKS) : 1;
    localparam logic [BCW-1:0] B_LAST = BCW'(BURST_TICKS - 1);

    logic [BCW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n || start_i) begin
            cnt_q <= '0;
        end else if (tick_i && cnt_q != B_LAST) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign done_o = tick_i && (cnt_q == B_LAST) && !start_i;

    AST_BURST_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (cnt_q == '0)); // R8
endmodule

// File: rtl/clkstop_fsm.sv
module clkstop_fsm
    import clkstop_pkg::*;
#(
    parameter int DUTY_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_enable_i,
    input  logic              thr_enable_i,
    input  logic              burst_mode_i,
    input  logic              entry_rd_i,
    input  logic              hw_event_i,
    input  logic [DUTY_W-1:0] duty_i,
    input  logic [DUTY_W-1:0] phase_i,
    input  logic              burst_done_i,
    output logic              throttling_o,
    output logic              burst_start_o,
    output logic              stop_o
);
    thr_state_e state_q, state_d, saved_q;
    logic brk_ev, bst_ev;

    assign brk_ev = hw_event_i && !burst_mode_i;
    assign bst_ev = hw_event_i &&  burst_mode_i;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN: begin
                if (ctl_enable_i && thr_enable_i)
                    state_d = entry_rd_i ? ST_HOLD_THR : ST_THROTTLE;
                else if (ctl_enable_i && entry_rd_i)
                    state_d = ST_HOLD;
            end
            ST_THROTTLE: begin
                if (!ctl_enable_i || !thr_enable_i) state_d = ST_RUN;
                else if (bst_ev)                    state_d = ST_BURST;
                else if (entry_rd_i)                state_d = ST_HOLD_THR;
            end
            ST_HOLD_THR: begin
                if (!ctl_enable_i || !thr_enable_i) state_d = ST_RUN;
                else if (bst_ev)                    state_d = ST_BURST;
                else if (brk_ev)                    state_d = ST_THROTTLE;
            end
            ST_HOLD: begin
                if (!ctl_enable_i)      state_d = ST_RUN;
                else if (bst_ev)        state_d = ST_BURST;
                else if (brk_ev)        state_d = ST_RUN;
                else if (thr_enable_i)  state_d = ST_THROTTLE;
            end
            ST_BURST: begin
                if (!ctl_enable_i)      state_d = ST_RUN;
                else if (bst_ev)        state_d = ST_BURST;
                else if (burst_done_i)  state_d = saved_q;
            end
            default: state_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
            saved_q <= ST_RUN;
        end else begin
            state_q <= state_d;
            if (state_d == ST_BURST && state_q != ST_BURST)
                saved_q <= state_q;
        end
    end

    always_comb begin
        throttling_o  = (state_q == ST_THROTTLE);
        burst_start_o = (state_d == ST_BURST) && ((state_q != ST_BURST) || bst_ev);
        unique case (state_q)
            ST_THROTTLE: stop_o = (phase_i < duty_i);
            ST_HOLD_THR,
            ST_HOLD:     stop_o = 1'b1;
            default:     stop_o = 1'b0;
        endcase
    end

    AST_BREAK_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_THROTTLE && ctl_enable_i && thr_enable_i && brk_ev && !entry_rd_i)
        |=> (state_q == ST_THROTTLE)); // R4
    AST_READ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_THROTTLE && ctl_enable_i && thr_enable_i && entry_rd_i && !hw_event_i)
        |=> (state_q == ST_HOLD_THR)); // R5
    AST_BREAK_RESUMES: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD_THR && ctl_enable_i && thr_enable_i && brk_ev)
        |=> (state_q == ST_THROTTLE)); // R6
    AST_BREAK_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD && ctl_enable_i && brk_ev) |=> (state_q == ST_RUN)); // R7
    AST_BURST_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_RUN && bst_ev) |=> !stop_o); // R8
endmodule

// File: rtl/clkstop_throttle.sv
module clkstop_throttle #(
    parameter int DUTY_W      = 3,
    parameter int BURST_TICKS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              ctl_enable_i,
    input  logic              thr_enable_i,
    input  logic              burst_mode_i,
    input  logic              sleep_follow_i,
    input  logic [DUTY_W-1:0] duty_i,
    input  logic              entry_rd_i,
    input  logic              hw_event_i,
    output logic              clk_stop_o,
    output logic              cache_sleep_o
);
    logic [DUTY_W-1:0] phase;
    logic throttling, burst_start, burst_done, stop;

    clkstop_phase #(.DUTY_W(DUTY_W)) u_phase (
        .clk(clk), .rst_n(rst_n), .run_i(throttling), .tick_i(tick_i), .phase_o(phase)
    );

    clkstop_burst #(.BURST_TICKS(BURST_TICKS)) u_burst (
        .clk(clk), .rst_n(rst_n), .start_i(burst_start), .tick_i(tick_i), .done_o(burst_done)
    );

    clkstop_fsm #(.DUTY_W(DUTY_W)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .ctl_enable_i(ctl_enable_i), .thr_enable_i(thr_enable_i),
        .burst_mode_i(burst_mode_i), .entry_rd_i(entry_rd_i), .hw_event_i(hw_event_i),
        .duty_i(duty_i), .phase_i(phase), .burst_done_i(burst_done),
        .throttling_o(throttling), .burst_start_o(burst_start), .stop_o(stop)
    );

    assign clk_stop_o    = stop;
    assign cache_sleep_o = stop && sleep_follow_i;

    AST_DISABLE_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_enable_i |=> !clk_stop_o); // R9
    AST_THR_CLEAR_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        (!thr_enable_i && $past(thr_enable_i) && throttling) |=> !clk_stop_o); // R3
endmodule

// File: tb/clkstop_throttle_tb.sv
`timescale 1ns/1ps
module clkstop_throttle_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick_i = 1'b0, ctl_enable_i = 1'b0, thr_enable_i = 1'b0;
    logic burst_mode_i = 1'b0, sleep_follow_i = 1'b0;
    logic [2:0] duty_i = 3'd0;
    logic entry_rd_i = 1'b0, hw_event_i = 1'b0;
    logic clk_stop_o, cache_sleep_o;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    // {sleep_follow, duty}
    localparam logic [3:0] VEC [0:5] = '{4'b0_000, 4'b1_001, 4'b0_011,
                                          4'b1_100, 4'b1_111, 4'b0_110};

    always #2.5 clk = ~clk;

    clkstop_throttle u_dut (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .ctl_enable_i(ctl_enable_i),
        .thr_enable_i(thr_enable_i), .burst_mode_i(burst_mode_i),
        .sleep_follow_i(sleep_follow_i), .duty_i(duty_i), .entry_rd_i(entry_rd_i),
        .hw_event_i(hw_event_i), .clk_stop_o(clk_stop_o), .cache_sleep_o(cache_sleep_o)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic tick();
        tick_i = 1'b1; step(); tick_i = 1'b0;
    endtask

    task automatic pulse_rd();
        entry_rd_i = 1'b1; step(); entry_rd_i = 1'b0;
    endtask

    task automatic pulse_ev();
        hw_event_i = 1'b1; step(); hw_event_i = 1'b0;
    endtask

    task automatic chk(input logic act, input logic exp, input string req);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0b expected %0b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; tick_i = 0; ctl_enable_i = 0; thr_enable_i = 0;
        burst_mode_i = 0; sleep_follow_i = 0; duty_i = 0; entry_rd_i = 0; hw_event_i = 0;
        step(); step();
        rst_n = 1'b1;
        step();
    endtask

    initial begin
        do_reset();
        chk(clk_stop_o, 1'b0, "R1 reset stop");
        chk(cache_sleep_o, 1'b0, "R1 reset sleep");
        pulse_rd();
        chk(clk_stop_o, 1'b0, "R1 read ignored when disabled");
        ctl_enable_i = 1'b1; step();
        pulse_ev();
        chk(clk_stop_o, 1'b0, "R1 event ignored when idle");

        // vector sweep: R2 and R10
        for (int v = 0; v < 6; v++) begin
            ctl_enable_i = 0; thr_enable_i = 0; step();
            sleep_follow_i = VEC[v][3]; duty_i = VEC[v][2:0];
            ctl_enable_i = 1; thr_enable_i = 1; step();
            for (int k = 0; k < 9; k++) begin
                chk(clk_stop_o, ((k % 8) < int'(VEC[v][2:0])), "R2 duty pattern");
                chk(cache_sleep_o, ((k % 8) < int'(VEC[v][2:0])) && VEC[v][3], "R10 sleep follow");
                tick();
            end
        end

        // R3: clear throttle enable
        do_reset();
        duty_i = 3'd7; ctl_enable_i = 1; thr_enable_i = 1; step();
        chk(clk_stop_o, 1'b1, "R3 throttling before clear");
        thr_enable_i = 0; step();
        chk(clk_stop_o, 1'b0, "R3 released after clear");

        // R4: break ignored while throttling
        duty_i = 3'd4; thr_enable_i = 1; step();
        pulse_ev();
        chk(clk_stop_o, 1'b1, "R4 break ignored");
        for (int k = 1; k < 5; k++) begin
            tick();
            chk(clk_stop_o, (k < 4), "R4 phase kept");
        end

        // R5 / R6
        ctl_enable_i = 0; step(); ctl_enable_i = 1;
        duty_i = 3'd2; step();
        tick(); tick(); tick();
        chk(clk_stop_o, 1'b0, "R5 phase 3 off");
        pulse_rd();
        chk(clk_stop_o, 1'b1, "R5 continuous stop");
        for (int k = 0; k < 8; k++) begin
            tick();
            chk(clk_stop_o, 1'b1, "R5 stop held across ticks");
        end
        pulse_ev();
        chk(clk_stop_o, 1'b1, "R6 resumes at phase 0");
        tick();
        chk(clk_stop_o, 1'b1, "R6 phase 1");
        tick();
        chk(clk_stop_o, 1'b0, "R6 phase 2");

        // R7 and R11
        do_reset();
        ctl_enable_i = 1; step();
        chk(clk_stop_o, 1'b0, "R7 idle before read");
        pulse_rd();
        chk(clk_stop_o, 1'b1, "R7 held stop");
        tick(); tick();
        chk(clk_stop_o, 1'b1, "R7 held across ticks");
        pulse_ev();
        chk(clk_stop_o, 1'b0, "R7 break releases");
        tick(); tick();
        chk(clk_stop_o, 1'b0, "R7 stays released");
        pulse_rd();
        chk(clk_stop_o, 1'b1, "R7 new read re-enters");
        duty_i = 3'd0; thr_enable_i = 1; step();
        chk(clk_stop_o, 1'b0, "R11 hold upgrades to throttling");
        duty_i = 3'd1; step();
        chk(clk_stop_o, 1'b1, "R11 throttling at phase 0");

        // R8: burst window from the plain hold
        do_reset();
        ctl_enable_i = 1; burst_mode_i = 1; step();
        pulse_rd();
        pulse_ev();
        chk(clk_stop_o, 1'b0, "R8 burst opens");
        for (int k = 1; k < 8; k++) begin
            tick();
            chk(clk_stop_o, 1'b0, "R8 window open");
        end
        tick();
        chk(clk_stop_o, 1'b1, "R8 hold resumes on 8th tick");
        pulse_ev();
        for (int k = 0; k < 4; k++) tick();
        pulse_ev();
        for (int k = 1; k < 8; k++) begin
            tick();
            chk(clk_stop_o, 1'b0, "R8 retriggered window");
        end
        tick();
        chk(clk_stop_o, 1'b1, "R8 resumes after retrigger");

        // R9: disable from inside a burst
        pulse_ev();
        tick();
        ctl_enable_i = 0; step();
        chk(clk_stop_o, 1'b0, "R9 disabled in burst");
        ctl_enable_i = 1;
        for (int k = 0; k < 9; k++) tick();
        chk(clk_stop_o, 1'b0, "R9 idle after disable");

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got hang expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule